// File: doc/BRIEF.md
# Pipelined Vectoring Phase Detector

This block measures the instantaneous phase of two complex sample streams, lane A and lane B, and forms the wrapped phase difference between them. Each lane carries a signed in-phase and quadrature pair. The lane rotates its vector onto the positive real axis through a chain of shift-and-add micro-rotations and accumulates the rotation angle. No multipliers are used. The rotated real part is the lane's magnitude, as a by-product.

Both lanes share one valid strobe. A new pair can enter on every clock. After a fixed latency of 18 clocks, one result per clock leaves the block. Vectors in the left half-plane are negated before the rotation chain, which then only has to cover ±π/2. The lost half-turn is restored at the output. A tag travels with each sample so that the correction lands on the sample it belongs to.

Angles use 16-bit two's complement: the value 2^15 corresponds to π, so −π maps to −32768 and +π wraps to the same code. A loop filter can consume the difference output directly as a phase error.

Top module: `cpd_vector_phase`

## Requirements
- R1: For a valid sample with |(I,Q)| ≥ 8000, each phase output equals round(atan2(Q, I)·32768/π) within ±24 LSB, where the comparison is taken modulo 2^16.
- R2: `vld_o` is `vld_i` delayed by exactly 18 clocks. A sample can be accepted on every clock, and idle cycles in between do not disturb the results.
- R3: With the default MAG_COMP = 0, each magnitude output equals 1.64676·sqrt(I² + Q²) within 0.5 % + 8 LSB. This holds for full-scale inputs including −32768 on either axis, and the 18-bit output never sets its top bit.
- R4: For an input with I < 0 (quadrants II and III), the result lies in the left half-plane: |phase| ≥ π/2, within tolerance. Q ≥ 0 gives a positive angle near +π. Q < 0 gives a negative angle near −π.
- R5: The input (0, 0) yields phase 0 and magnitude 0 exactly.
- R6: `phase_diff_o` equals phase A minus phase B modulo 2^16, taken on the same sample.
- R7: While `rst_ni` is low and in the first cycle after it is released, `vld_o` is 0 and the phase outputs are 0.
- R8: Each result belongs to the sample that entered 18 clocks earlier, even when consecutive samples differ strongly in angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input pair valid for both lanes |
| i_a_i | input | 16 | Lane A in-phase, signed |
| q_a_i | input | 16 | Lane A quadrature, signed |
| i_b_i | input | 16 | Lane B in-phase, signed |
| q_b_i | input | 16 | Lane B quadrature, signed |
| vld_o | output | 1 | Results valid |
| phase_a_o | output | 16 | Lane A phase, 2^15 = π |
| phase_b_o | output | 16 | Lane B phase, 2^15 = π |
| phase_diff_o | output | 16 | Wrapped phase A − phase B |
| mag_a_o | output | 18 | Lane A magnitude, gain-scaled |
| mag_b_o | output | 18 | Lane B magnitude, gain-scaled |

## Verification
The hardest conditions to reach are the ones at the edge of the left half-plane. One is the seam at ±π: a vector with large negative I and a quadrature of +1 or −1 must come out near +π or −π. Another is full-scale −32768 on an axis, which must not overflow when it is negated and then grows by the rotation gain. The stimulus places these vectors directly and mixes them with an angle sweep and random polar vectors. Idle cycles are spread through the stream so that any misalignment of the half-turn tag would show on a neighbouring sample. A behavioural model based on atan2 and sqrt predicts every output cycle.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned GUARD_W = 2;
  localparam int unsigned ANG_W   = 16;
  localparam int unsigned N_ROT   = 16;
  localparam int unsigned XW      = DATA_W + GUARD_W;
  localparam int unsigned LAT     = N_ROT + 2;

  localparam logic signed [ANG_W-1:0] ANG_PI = {1'b1, {(ANG_W-1){1'b0}}};

  typedef enum logic [1:0] {
    QD_RIGHT = 2'd0,
    QD_UPPER = 2'd1,
    QD_LOWER = 2'd2
  } quad_e;

  typedef struct packed {
    logic                    vld;
    logic                    zero;
    quad_e                   quad;
    logic signed [XW-1:0]    x;
    logic signed [XW-1:0]    y;
    logic signed [ANG_W-1:0] z;
  } cpd_stage_t;

  // arctan(2^-n) scaled so that 2^15 = pi at 16 bits
  function automatic logic signed [ANG_W-1:0] atan_step(int n);
    logic [31:0] v;
    case (n)
      0: v = 32'd8192;  1: v = 32'd4836;  2: v = 32'd2555;  3: v = 32'd1297;
      4: v = 32'd651;   5: v = 32'd326;   6: v = 32'd163;   7: v = 32'd81;
      8: v = 32'd41;    9: v = 32'd20;   10: v = 32'd10;   11: v = 32'd5;
     12: v = 32'd3;    13: v = 32'd1;    14: v = 32'd1;    default: v = 32'd0;
    endcase
    return ANG_W'(v << (ANG_W - 16));
  endfunction
endpackage

// File: rtl/cpd_prefold.sv
module cpd_prefold
  import cpd_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  output cpd_stage_t               st_o
);
  cpd_stage_t nxt;
  logic signed [XW-1:0] xe, ye;

  always_comb begin
    xe       = XW'(i_i);
    ye       = XW'(q_i);
    nxt      = '0;
    nxt.vld  = vld_i;
    nxt.zero = (i_i == '0) && (q_i == '0);
    if (i_i[DATA_W-1]) begin
      // left half-plane: rotate by pi, fix up at the end
      nxt.x    = -xe;
      nxt.y    = -ye;
      nxt.quad = q_i[DATA_W-1] ? QD_LOWER : QD_UPPER;
    end else begin
      nxt.x    = xe;
      nxt.y    = ye;
      nxt.quad = QD_RIGHT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= '0;
    else         st_o <= nxt;
  end
endmodule

// File: rtl/cpd_micro_rot.sv
module cpd_micro_rot
  import cpd_pkg::*;
#(
  parameter int unsigned STAGE = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cpd_stage_t st_i,
  output cpd_stage_t st_o
);
  localparam logic signed [ANG_W-1:0] ANG = atan_step(int'(STAGE));

  cpd_stage_t nxt;
  logic signed [XW-1:0] xs, ys;

  always_comb begin
    xs  = st_i.x >>> STAGE;
    ys  = st_i.y >>> STAGE;
    nxt = st_i;
    if (!st_i.y[XW-1]) begin
      nxt.x = st_i.x + ys;
      nxt.y = st_i.y - xs;
      nxt.z = st_i.z + ANG;
    end else begin
      nxt.x = st_i.x - ys;
      nxt.y = st_i.y + xs;
      nxt.z = st_i.z - ANG;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= '0;
    else         st_o <= nxt;
  end
endmodule

// File: rtl/cpd_post.sv
module cpd_post
  import cpd_pkg::*;
#(
  parameter bit MAG_COMP = 1'b0
) (
  input  cpd_stage_t              st_i,
  output logic signed [ANG_W-1:0] phase_o,
  output logic        [XW-1:0]    mag_o
);
  always_comb begin
    if (st_i.zero) phase_o = '0;
    else begin
      unique case (st_i.quad)
        QD_UPPER: phase_o = st_i.z + ANG_PI;
        QD_LOWER: phase_o = st_i.z - ANG_PI;
        default:  phase_o = st_i.z;
      endcase
    end
  end

  generate
    if (MAG_COMP) begin : g_comp
      // 1/1.6468 ~ 2^-1 + 2^-3 - 2^-6 - 2^-9
      always_comb
        mag_o = (st_i.x >>> 1) + (st_i.x >>> 3) - (st_i.x >>> 6) - (st_i.x >>> 9);
    end else begin : g_raw
      always_comb mag_o = st_i.x;
    end
  endgenerate
endmodule

// File: rtl/cpd_vector_phase.sv
module cpd_vector_phase
  import cpd_pkg::*;
#(
  parameter bit MAG_COMP = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] i_a_i,
  input  logic signed [DATA_W-1:0] q_a_i,
  input  logic signed [DATA_W-1:0] i_b_i,
  input  logic signed [DATA_W-1:0] q_b_i,
  output logic                     vld_o,
  output logic signed [ANG_W-1:0]  phase_a_o,
  output logic signed [ANG_W-1:0]  phase_b_o,
  output logic signed [ANG_W-1:0]  phase_diff_o,
  output logic        [XW-1:0]     mag_a_o,
  output logic        [XW-1:0]     mag_b_o
);
  localparam int unsigned N_CH = 2;

  logic signed [DATA_W-1:0] in_i [N_CH];
  logic signed [DATA_W-1:0] in_q [N_CH];
  cpd_stage_t               pipe [N_CH][N_ROT+1];
  logic signed [ANG_W-1:0]  ph   [N_CH];
  logic        [XW-1:0]     mg   [N_CH];

  assign in_i[0] = i_a_i;
  assign in_q[0] = q_a_i;
  assign in_i[1] = i_b_i;
  assign in_q[1] = q_b_i;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      cpd_prefold u_fold (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .vld_i (vld_i),
        .i_i   (in_i[c]),
        .q_i   (in_q[c]),
        .st_o  (pipe[c][0])
      );
      for (genvar s = 0; s < N_ROT; s++) begin : g_rot
        cpd_micro_rot #(.STAGE(s)) u_rot (
          .clk_i (clk_i),
          .rst_ni(rst_ni),
          .st_i  (pipe[c][s]),
          .st_o  (pipe[c][s+1])
        );
      end
      cpd_post #(.MAG_COMP(MAG_COMP)) u_post (
        .st_i   (pipe[c][N_ROT]),
        .phase_o(ph[c]),
        .mag_o  (mg[c])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      phase_a_o    <= '0;
      phase_b_o    <= '0;
      phase_diff_o <= '0;
      mag_a_o      <= '0;
      mag_b_o      <= '0;
    end else begin
      vld_o        <= pipe[0][N_ROT].vld;
      phase_a_o    <= ph[0];
      phase_b_o    <= ph[1];
      phase_diff_o <= ph[0] - ph[1];
      mag_a_o      <= mg[0];
      mag_b_o      <= mg[1];
    end
  end
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker
  import cpd_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     vld_i,
  input logic signed [DATA_W-1:0] i_a_i,
  input logic signed [DATA_W-1:0] q_a_i,
  input logic                     vld_o,
  input logic signed [ANG_W-1:0]  phase_a_o,
  input logic        [XW-1:0]     mag_a_o,
  input logic        [XW-1:0]     mag_b_o
);
  localparam int QUARTER = 1 << (ANG_W - 2);
  localparam int TOL     = 24;

  logic [LAT-1:0] vld_sr, zero_sr, left_sr, right_sr;
  int abs_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_sr   <= '0;
      zero_sr  <= '0;
      left_sr  <= '0;
      right_sr <= '0;
    end else begin
      vld_sr   <= {vld_sr[LAT-2:0], vld_i};
      zero_sr  <= {zero_sr[LAT-2:0], (i_a_i == '0) && (q_a_i == '0)};
      left_sr  <= {left_sr[LAT-2:0], i_a_i[DATA_W-1]};
      right_sr <= {right_sr[LAT-2:0], !i_a_i[DATA_W-1] && !((i_a_i == '0) && (q_a_i == '0))};
    end
  end

  always_comb abs_ph = phase_a_o[ANG_W-1] ? -int'(phase_a_o) : int'(phase_a_o);

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == vld_sr[LAT-1]);

  assert_zero_input_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && zero_sr[LAT-1]) |-> (phase_a_o == '0 && mag_a_o == '0));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (!mag_a_o[XW-1] && !mag_b_o[XW-1]));

  assert_right_half_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && right_sr[LAT-1]) |-> (abs_ph <= QUARTER + TOL));

  assert_left_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && left_sr[LAT-1]) |-> (abs_ph >= QUARTER - TOL));
endmodule

bind cpd_vector_phase cpd_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vld_i    (vld_i),
  .i_a_i    (i_a_i),
  .q_a_i    (q_a_i),
  .vld_o    (vld_o),
  .phase_a_o(phase_a_o),
  .mag_a_o  (mag_a_o),
  .mag_b_o  (mag_b_o)
);

// File: tb/cpd_vector_phase_tb.sv
module cpd_vector_phase_tb;
  localparam int    LAT  = 18;
  localparam int    TOL  = 24;
  localparam real   PI   = 3.14159265358979;
  localparam real   GAIN = 1.646760258;

  typedef struct {
    bit  vld;
    int  ia, qa, ib, qb;
  } smp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vld_i = 1'b0;
  logic signed [15:0] i_a_i = '0, q_a_i = '0, i_b_i = '0, q_b_i = '0;
  logic vld_o;
  logic signed [15:0] phase_a_o, phase_b_o, phase_diff_o;
  logic [17:0] mag_a_o, mag_b_o;

  int n_cmp = 0, n_bad = 0;
  smp_t q[$];

  always #4 clk = ~clk;

  cpd_vector_phase u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i),
    .i_a_i(i_a_i), .q_a_i(q_a_i), .i_b_i(i_b_i), .q_b_i(q_b_i),
    .vld_o(vld_o), .phase_a_o(phase_a_o), .phase_b_o(phase_b_o),
    .phase_diff_o(phase_diff_o), .mag_a_o(mag_a_o), .mag_b_o(mag_b_o)
  );

  function automatic int wrap16(int v);
    return ((v % 65536) + 65536 + 32768) % 65536 - 32768;
  endfunction

  function automatic int exp_phase(int i, int qq);
    if (i == 0 && qq == 0) return 0;
    return wrap16(int'($atan2(real'(qq), real'(i)) * 32768.0 / PI));
  endfunction

  function automatic int exp_mag(int i, int qq);
    return int'(GAIN * $sqrt(real'(i) * i + real'(qq) * qq));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_phase(int act, int i, int qq, string what);
    int e, d;
    string req;
    e = exp_phase(i, qq);
    d = wrap16(act - e);
    if (i == 0 && qq == 0) req = "R5";
    else if (i < 0) req = "R4";
    else req = "R1";
    chk((i == 0 && qq == 0) ? (d == 0) : (d <= TOL && d >= -TOL), req, what, act, e);
  endtask

  task automatic chk_mag(int act, int i, int qq, string what);
    int e;
    e = exp_mag(i, qq);
    chk((act - e <= e / 200 + 8) && (e - act <= e / 200 + 8),
        (i == 0 && qq == 0) ? "R5" : "R3", what, act, e);
  endtask

  task automatic compare(smp_t s);
    int d;
    chk(vld_o == s.vld, "R2 R8", "vld_o", int'(vld_o), int'(s.vld));
    if (s.vld) begin
      chk_phase(int'(phase_a_o), s.ia, s.qa, "phase_a");
      chk_phase(int'(phase_b_o), s.ib, s.qb, "phase_b");
      chk_mag(int'(mag_a_o), s.ia, s.qa, "mag_a");
      chk_mag(int'(mag_b_o), s.ib, s.qb, "mag_b");
      d = wrap16(int'(phase_diff_o) - wrap16(exp_phase(s.ia, s.qa) - exp_phase(s.ib, s.qb)));
      chk(d <= 2 * TOL && d >= -2 * TOL, "R6", "phase_diff", int'(phase_diff_o),
          wrap16(exp_phase(s.ia, s.qa) - exp_phase(s.ib, s.qb)));
    end
  endtask

  task automatic step(bit v, int ia, int qa, int ib, int qb);
    smp_t s;
    @(negedge clk);
    if (q.size() == LAT) compare(q.pop_front());
    vld_i = v;
    i_a_i = 16'(ia); q_a_i = 16'(qa);
    i_b_i = 16'(ib); q_b_i = 16'(qb);
    s.vld = v; s.ia = ia; s.qa = qa; s.ib = ib; s.qb = qb;
    q.push_back(s);
  endtask

  task automatic polar(bit v, real amp, real ang, real ampb, real angb);
    step(v, int'(amp * $cos(ang)), int'(amp * $sin(ang)),
         int'(ampb * $cos(angb)), int'(ampb * $sin(angb)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(vld_o == 1'b0, "R7", "vld_o in reset", int'(vld_o), 0);
    chk(phase_a_o == 0 && phase_diff_o == 0, "R7", "phase in reset", int'(phase_a_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(vld_o == 1'b0, "R7", "vld_o after release", int'(vld_o), 0);

    // full-scale and seam corners (R3, R4, R5)
    step(1, -32768, 0, 32767, 0);
    step(1, -32768, -32768, 32767, 32767);
    step(1, 0, -32768, 0, 32767);
    step(1, -32768, 32767, -32767, -32768);
    step(1, -8000, 1, -8000, -1);
    step(1, 0, 0, 20000, -20000);
    step(1, 12000, 0, 0, 0);
    step(1, -20000, 0, 0, -12000);
    step(0, 1, 2, 3, 4);
    step(1, 0, 0, 0, 0);

    // angle sweep, back-to-back (R1, R8)
    for (int k = 0; k < 72; k++)
      polar(1, 20000.0, k * 2.0 * PI / 72.0, 9000.0, -k * 2.0 * PI / 36.0);

    // random polar vectors with idle gaps (R2, R8)
    for (int k = 0; k < 400; k++) begin
      real a1, a2, r1, r2;
      a1 = ($urandom % 3600) * 2.0 * PI / 3600.0;
      a2 = ($urandom % 3600) * 2.0 * PI / 3600.0;
      r1 = 8000.0 + ($urandom % 24000);
      r2 = 8000.0 + ($urandom % 24000);
      polar(($urandom % 4) != 0, r1, a1, r2, a2);
    end

    for (int k = 0; k < LAT + 2; k++) step(0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule